// File: doc/BRIEF.md
# Prioritized External Interrupt Controller

This block collects one non-maskable edge input and six maskable external request pins. It holds a pending state for each source and offers the single most urgent request to the CPU through a request/acknowledge handshake. The non-maskable input is edge triggered, and a configuration bit selects its polarity. Maskable source 0 is level sensitive and active low. It must stay asserted until the CPU accepts it. Maskable sources 1 to 5 each latch a falling edge in a pending flag, and the flag stays set until that source is served.

Each maskable source has a 3-bit priority. A source takes part in arbitration only when its priority is strictly above the CPU mask level. Arbitration is purely combinational, so the winner is decided in the cycle the acknowledge arrives. When the CPU accepts a maskable source, the mask level takes that source's priority. A source can also be routed to a transfer engine. The block then dispatches it by itself with a one-cycle start pulse, and the CPU never sees it. Configuration uses a byte-wide write port. The mask can be written directly, for example when software returns from a handler.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset `irq_req`, `xfer_start`, `ack_id` and `mask_level` are all zero. All enables, priorities and routing bits are cleared, and the non-maskable polarity selects the falling edge.
- R2: Configuration address 1 bit 0 selects the non-maskable edge: 1 for rising, 0 for falling. The opposite edge is ignored. A pending non-maskable request is presented with ID 7 and priority 7 whatever the mask level, and it wins over every maskable request.
- R3: Acknowledging the non-maskable request clears it. If a qualifying edge arrives in the same cycle as the acknowledge, the request stays pending and is presented again.
- R4: Source 0 is requested while its pin is low and its enable bit is 1. It disappears if the pin rises before acceptance. Once accepted, it is not presented again until its pin has gone high and then low.
- R5: Sources 1 to 5 latch a high-to-low pin transition only while their enable bit is 1. Edges seen while disabled are dropped. A latched flag stays pending after the pin returns high.
- R6: Configuration address 0 bit i enables source i, and address 4 bit i routes source i to the transfer engine. Address 2 bits [2:0] set the priority of source 0 and bits [6:4] that of source 1. Address 3 bits [2:0] set sources 2 and 3 together, and bits [6:4] set sources 4 and 5 together. Bits 3 and 7 of each priority byte are ignored.
- R7: A maskable request is presented only if its priority is strictly greater than `mask_level`.
- R8: Among eligible sources the highest priority wins, and on equal priority the lower index wins. Sources that lose stay pending.
- R9: When `irq_ack` is high while `irq_req` is high, the following happens at the next edge. `ack_id` captures `irq_id`, the source is cleared, and for a maskable source `mask_level` takes its priority. A non-maskable acknowledge leaves the mask unchanged. `irq_ack` has no effect while `irq_req` is low.
- R10: `mask_we` loads `mask_level` from `mask_wdata`. An accepted acknowledge in the same cycle takes precedence.
- R11: A winning source that is routed to the transfer engine is not presented to the CPU. In the next cycle `xfer_start` bit i pulses for exactly one cycle, the source's pending state is cleared and `mask_level` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable edge input |
| irq_pin_n | input | 6 | Maskable request pins, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| mask_we | input | 1 | Direct mask write strobe |
| mask_wdata | input | 3 | Value for direct mask write |
| irq_ack | input | 1 | CPU accepts the presented request |
| irq_req | output | 1 | A request is presented to the CPU |
| irq_id | output | 3 | Presented source, 0 to 5 or 7 for non-maskable |
| irq_prio | output | 3 | Priority of the presented source |
| ack_id | output | 3 | Source captured at the last acceptance |
| mask_level | output | 3 | Current CPU mask level |
| xfer_start | output | 6 | One-cycle start pulse per source to the transfer engine |

## Verification
A vector table drives arbitration with single sources, pairs, shared-nibble ties and the full set of six sources. It moves the mask across each winner's priority, so the strict comparison, the lowest-index tie rule and the masking of the reserved priority bits can each be told apart. Directed sequences then cover the rest. They run the non-maskable input in both polarities and with an edge that coincides with the acknowledge, which separates re-arming from plain clearing. They take the level source through withdrawal, acceptance and re-arming. They check that losing sources are served in order as the mask drops, and that a routed source produces a single start pulse and no CPU request.

// File: rtl/eirq_pkg.sv
`timescale 1ns/1ps
// Shared constants for the external interrupt controller: source count,
// field widths, configuration addresses and the priority nibble map.
package eirq_pkg;
    localparam int N_SRC  = 6;
    localparam int PRIO_W = 3;
    localparam int ID_W   = 3;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int N_NIB  = 4;

    localparam logic [ID_W-1:0]   NMI_ID   = 3'd7;
    localparam logic [PRIO_W-1:0] NMI_PRIO = 3'd7;

    localparam logic [ADDR_W-1:0] A_EN   = 3'd0;
    localparam logic [ADDR_W-1:0] A_POL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_PRA  = 3'd2;
    localparam logic [ADDR_W-1:0] A_PRB  = 3'd3;
    localparam logic [ADDR_W-1:0] A_XFER = 3'd4;

    // Priority nibble that serves a source: 0,1 private; 2/3 and 4/5 shared.
    function automatic int nib_of(input int s);
        return (s < 2) ? s : (s + 2) / 2;
    endfunction
endpackage

// File: rtl/eirq_cfg_regs.sv
`timescale 1ns/1ps
// Configuration store: enables, non-maskable polarity, priority nibbles
// and transfer routing. Assumes single-cycle write strobes; only the low
// PRIO_W bits of each nibble are kept.
module eirq_cfg_regs #(
    parameter int N      = eirq_pkg::N_SRC,
    parameter int PW     = eirq_pkg::PRIO_W,
    parameter int AW     = eirq_pkg::ADDR_W,
    parameter int DW     = eirq_pkg::DATA_W,
    parameter int NNIB   = eirq_pkg::N_NIB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [N-1:0]         en,
    output logic                 nmi_rise,
    output logic [N-1:0]         xfer_en,
    output logic [N-1:0][PW-1:0] prio
);
    logic [NNIB-1:0][PW-1:0] nib;

    // Register writes decoded by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= '0;
            nmi_rise <= 1'b0;
            xfer_en  <= '0;
            nib      <= '0;
        end else if (we) begin
            case (addr)
                eirq_pkg::A_EN:   en       <= wdata[N-1:0];
                eirq_pkg::A_POL:  nmi_rise <= wdata[0];
                eirq_pkg::A_XFER: xfer_en  <= wdata[N-1:0];
                eirq_pkg::A_PRA: begin
                    nib[0] <= wdata[PW-1:0];
                    nib[1] <= wdata[4 +: PW];
                end
                eirq_pkg::A_PRB: begin
                    nib[2] <= wdata[PW-1:0];
                    nib[3] <= wdata[4 +: PW];
                end
                default: ;
            endcase
        end
    end

    // Fan each nibble out to the sources it serves.
    for (genvar i = 0; i < N; i++) begin : g_map
        localparam int NB = eirq_pkg::nib_of(i);
        assign prio[i] = nib[NB];
    end
endmodule

// File: rtl/eirq_src.sv
`timescale 1ns/1ps
// One maskable source. LEVEL=1: active-low level request, blocked after
// service until the pin returns high. LEVEL=0: falling-edge pending flag,
// set only while enabled, cleared by service; a new edge wins over clear.
// Assumes the pin is synchronous to clk.
module eirq_src #(
    parameter bit LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic pin_n,
    input  logic en,
    input  logic clr,
    output logic active
);
    if (LEVEL) begin : g_level
        logic hold;
        // Block a served level request until the pin is released.
        always_ff @(posedge clk) begin
            if (!rst_n)     hold <= 1'b0;
            else if (pin_n) hold <= 1'b0;
            else if (clr)   hold <= 1'b1;
        end
        assign active = arm & en & ~pin_n & ~hold;
    end else begin : g_edge
        logic prev;
        logic flag;
        // Track the pin and latch an enabled falling edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev <= 1'b1;
                flag <= 1'b0;
            end else begin
                prev <= pin_n;
                if (arm && en && prev && !pin_n) flag <= 1'b1;
                else if (clr)                    flag <= 1'b0;
            end
        end
        assign active = flag;
    end
endmodule

// File: rtl/eirq_arbiter.sv
`timescale 1ns/1ps
// Combinational selection among maskable sources: only priorities strictly
// above the mask qualify; highest priority wins, lower index breaks ties.
module eirq_arbiter #(
    parameter int N  = eirq_pkg::N_SRC,
    parameter int PW = eirq_pkg::PRIO_W,
    parameter int IW = eirq_pkg::ID_W
) (
    input  logic [N-1:0]         active,
    input  logic [N-1:0][PW-1:0] prio,
    input  logic [PW-1:0]        mask,
    output logic                 win_valid,
    output logic [IW-1:0]        win_id,
    output logic [PW-1:0]        win_prio
);
    // Scan from the highest index so equal priorities fall to the lower one.
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_prio  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (active[i] && (prio[i] > mask) && (!win_valid || prio[i] >= win_prio)) begin
                win_valid = 1'b1;
                win_id    = IW'(i);
                win_prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
`timescale 1ns/1ps
// Top of the external interrupt controller. Presents the non-maskable
// request or the arbitrated maskable winner to the CPU, handles acceptance
// and mask update, and dispatches routed sources to the transfer engine.
// Assumes all pins are synchronous to clk.
module ext_irq_ctrl #(
    parameter int N_SRC  = eirq_pkg::N_SRC,
    parameter int PRIO_W = eirq_pkg::PRIO_W,
    parameter int ID_W   = eirq_pkg::ID_W,
    parameter int ADDR_W = eirq_pkg::ADDR_W,
    parameter int DATA_W = eirq_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pin,
    input  logic [N_SRC-1:0]  irq_pin_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              mask_we,
    input  logic [PRIO_W-1:0] mask_wdata,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [ID_W-1:0]   irq_id,
    output logic [PRIO_W-1:0] irq_prio,
    output logic [ID_W-1:0]   ack_id,
    output logic [PRIO_W-1:0] mask_level,
    output logic [N_SRC-1:0]  xfer_start
);
    localparam logic [N_SRC-1:0] ONE = N_SRC'(1);

    logic [N_SRC-1:0]             en, xfer_en, active, clr;
    logic [N_SRC-1:0][PRIO_W-1:0] prio;
    logic                         nmi_rise, arm, nmi_prev, nmi_pend, nmi_edge;
    logic                         win_valid, take_x, ack_ok;
    logic [ID_W-1:0]              win_id;
    logic [PRIO_W-1:0]            win_prio;
    logic [N_SRC-1:0]             win_oh;

    eirq_cfg_regs #(.N(N_SRC), .PW(PRIO_W), .AW(ADDR_W), .DW(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .en(en), .nmi_rise(nmi_rise), .xfer_en(xfer_en), .prio(prio)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        eirq_src #(.LEVEL(i == 0)) u_src (
            .clk(clk), .rst_n(rst_n), .arm(arm), .pin_n(irq_pin_n[i]),
            .en(en[i]), .clr(clr[i]), .active(active[i])
        );
    end

    eirq_arbiter #(.N(N_SRC), .PW(PRIO_W), .IW(ID_W)) u_arb (
        .active(active), .prio(prio), .mask(mask_level),
        .win_valid(win_valid), .win_id(win_id), .win_prio(win_prio)
    );

    // Presentation to the CPU and acceptance decode.
    always_comb begin
        win_oh   = ONE << win_id;
        take_x   = !nmi_pend && win_valid && xfer_en[win_id];
        irq_req  = nmi_pend || (win_valid && !xfer_en[win_id]);
        irq_id   = nmi_pend ? eirq_pkg::NMI_ID   : win_id;
        irq_prio = nmi_pend ? eirq_pkg::NMI_PRIO : win_prio;
        ack_ok   = irq_ack && irq_req;
        clr      = ((ack_ok && !nmi_pend) || take_x) ? win_oh : '0;
        nmi_edge = arm && (nmi_rise ? (!nmi_prev && nmi_pin) : (nmi_prev && !nmi_pin));
    end

    // Edge arming after reset and non-maskable edge latch (set beats clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm      <= 1'b0;
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            arm      <= 1'b1;
            nmi_prev <= nmi_pin;
            if (nmi_edge)                   nmi_pend <= 1'b1;
            else if (ack_ok && nmi_pend)    nmi_pend <= 1'b0;
        end
    end

    // Mask level, accepted ID and transfer start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_level <= '0;
            ack_id     <= '0;
            xfer_start <= '0;
        end else begin
            xfer_start <= take_x ? win_oh : '0;
            if (ack_ok) ack_id <= irq_id;
            if (ack_ok && !nmi_pend) mask_level <= win_prio;
            else if (mask_we)        mask_level <= mask_wdata;
        end
    end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for ext_irq_ctrl, attached by bind below.
module ext_irq_ctrl_chk #(
    parameter int N  = eirq_pkg::N_SRC,
    parameter int PW = eirq_pkg::PRIO_W,
    parameter int IW = eirq_pkg::ID_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_ack,
    input logic          irq_req,
    input logic [IW-1:0] irq_id,
    input logic [PW-1:0] irq_prio,
    input logic [IW-1:0] ack_id,
    input logic [PW-1:0] mask_level,
    input logic          mask_we,
    input logic [N-1:0]  xfer_start,
    input logic [N-1:0]  xfer_en
);
    p_above_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_id != eirq_pkg::NMI_ID) |-> (irq_prio > mask_level));

    p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && irq_id != eirq_pkg::NMI_ID) |=> (mask_level == $past(irq_prio)));

    p_ack_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> (ack_id == $past(irq_id)));

    p_ack_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_req && !mask_we) |=> ($stable(mask_level) && $stable(ack_id)));

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xfer_start));

    p_routed_hidden_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_id != eirq_pkg::NMI_ID) |-> !xfer_en[irq_id]);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .irq_req(irq_req),
    .irq_id(irq_id), .irq_prio(irq_prio), .ack_id(ack_id),
    .mask_level(mask_level), .mask_we(mask_we), .xfer_start(xfer_start),
    .xfer_en(xfer_en)
);

// File: tb/ext_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb;
    logic       clk = 1'b0, rst_n = 1'b0, nmi_pin = 1'b1;
    logic [5:0] pins = 6'h3F;
    logic       cfg_we = 1'b0, mask_we = 1'b0, irq_ack = 1'b0;
    logic [2:0] cfg_addr = '0, mask_wdata = '0;
    logic [7:0] cfg_wdata = '0;
    logic       irq_req;
    logic [2:0] irq_id, irq_prio, ack_id, mask_level;
    logic [5:0] xfer_start;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    ext_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pin_n(pins),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_id(irq_id), .irq_prio(irq_prio),
        .ack_id(ack_id), .mask_level(mask_level), .xfer_start(xfer_start)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [7:0] pa; logic [7:0] pb; logic [2:0] mask; logic [5:0] pat;
        logic req; logic [2:0] id; logic [2:0] pr;
    } vec_t;

    // Arbitration vectors (R6, R7, R8): priority bytes, mask, pins pulled low, expected.
    localparam vec_t VEC [10] = '{
        '{8'h00, 8'h00, 3'd0, 6'b000010, 1'b0, 3'd0, 3'd0},
        '{8'h30, 8'h00, 3'd0, 6'b000010, 1'b1, 3'd1, 3'd3},
        '{8'h52, 8'h00, 3'd4, 6'b000011, 1'b1, 3'd1, 3'd5},
        '{8'h52, 8'h00, 3'd5, 6'b000011, 1'b0, 3'd0, 3'd0},
        '{8'h33, 8'h33, 3'd0, 6'b111110, 1'b1, 3'd1, 3'd3},
        '{8'h33, 8'h33, 3'd0, 6'b111111, 1'b1, 3'd0, 3'd3},
        '{8'h11, 8'h61, 3'd0, 6'b101100, 1'b1, 3'd5, 3'd6},
        '{8'h11, 8'h66, 3'd0, 6'b110000, 1'b1, 3'd4, 3'd6},
        '{8'h0F, 8'h00, 3'd6, 6'b000001, 1'b1, 3'd0, 3'd7},
        '{8'h8C, 8'h00, 3'd0, 6'b000010, 1'b0, 3'd0, 3'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pins = 6'h3F; nmi_pin = 1'b1;
        cfg_we = 1'b0; mask_we = 1'b0; irq_ack = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        repeat (2) tick();
    endtask

    task automatic cfg(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic set_mask(input logic [2:0] m);
        mask_we = 1'b1; mask_wdata = m;
        tick();
        mask_we = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic expect_req(input string tag, input logic [2:0] id, input logic [2:0] pr);
        chk({tag, " req"}, 32'(irq_req), 1);
        chk({tag, " id"}, 32'(irq_id), 32'(id));
        chk({tag, " prio"}, 32'(irq_prio), 32'(pr));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        do_reset();
        chk("R1 irq_req", 32'(irq_req), 0);
        chk("R1 mask", 32'(mask_level), 0);
        chk("R1 xfer", 32'(xfer_start), 0);
        chk("R1 ack_id", 32'(ack_id), 0);

        // R6 R7 R8: vector table
        for (int k = 0; k < 10; k++) begin
            vec_t v;
            v = VEC[k];
            do_reset();
            cfg(3'd0, 8'h3F);
            cfg(3'd2, v.pa);
            cfg(3'd3, v.pb);
            set_mask(v.mask);
            pins = ~v.pat;
            tick(); tick();
            pins = {5'h1F, ~v.pat[0]};
            tick();
            chk($sformatf("R6/R8 vec%0d req", k), 32'(irq_req), 32'(v.req));
            if (v.req) begin
                chk($sformatf("R8 vec%0d id", k), 32'(irq_id), 32'(v.id));
                chk($sformatf("R6 vec%0d prio", k), 32'(irq_prio), 32'(v.pr));
            end
            pins = 6'h3F;
        end

        // R5: disabled edge dropped, enabled edge latched and held
        do_reset();
        pins[1] = 1'b0; tick(); tick(); pins[1] = 1'b1; tick();
        chk("R1 enables cleared", 32'(irq_req), 0);
        cfg(3'd0, 8'h02);
        cfg(3'd2, 8'h70);
        chk("R5 disabled edge dropped", 32'(irq_req), 0);
        ack();
        chk("R9 ignored ack id", 32'(ack_id), 0);
        chk("R9 ignored ack mask", 32'(mask_level), 0);
        pins[1] = 1'b0; tick(); pins[1] = 1'b1; tick();
        expect_req("R5 latched", 3'd1, 3'd7);

        // R2: non-maskable wins; R9 mask untouched on its ack; R8 loser kept
        nmi_pin = 1'b0; tick();
        expect_req("R2 nmi wins", 3'd7, 3'd7);
        nmi_pin = 1'b1;
        ack();
        chk("R9 nmi ack id", 32'(ack_id), 7);
        chk("R9 nmi mask kept", 32'(mask_level), 0);
        expect_req("R8 loser pending", 3'd1, 3'd7);
        ack();
        chk("R9 ack id", 32'(ack_id), 1);
        chk("R9 mask load", 32'(mask_level), 7);
        chk("R9 flag cleared", 32'(irq_req), 0);
        nmi_pin = 1'b0; tick();
        expect_req("R2 mask ignored", 3'd7, 3'd7);
        ack();
        chk("R2 nmi cleared", 32'(irq_req), 0);

        // R3: edge coinciding with ack re-arms
        nmi_pin = 1'b1; tick();
        chk("R2 rising ignored", 32'(irq_req), 0);
        nmi_pin = 1'b0; tick();
        nmi_pin = 1'b1; tick();
        nmi_pin = 1'b0; irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        expect_req("R3 rearmed", 3'd7, 3'd7);
        ack();
        chk("R3 cleared", 32'(irq_req), 0);

        // R2: rising polarity
        cfg(3'd1, 8'h01);
        nmi_pin = 1'b1; tick();
        expect_req("R2 rising edge", 3'd7, 3'd7);
        ack();
        nmi_pin = 1'b0; tick();
        chk("R2 falling ignored", 32'(irq_req), 0);

        // R10: direct mask write, ack precedence
        set_mask(3'd0);
        chk("R10 mask write", 32'(mask_level), 0);
        cfg(3'd3, 8'h04);
        cfg(3'd0, 8'h06);
        pins[2] = 1'b0; tick(); pins[2] = 1'b1; tick();
        expect_req("R6 shared nibble", 3'd2, 3'd4);
        irq_ack = 1'b1; mask_we = 1'b1; mask_wdata = 3'd1;
        tick();
        irq_ack = 1'b0; mask_we = 1'b0;
        chk("R10 ack precedence", 32'(mask_level), 4);
        chk("R9 ack id src2", 32'(ack_id), 2);

        // R7 R8: losers served in order as mask drops
        do_reset();
        cfg(3'd0, 8'h0E);
        cfg(3'd2, 8'h50);
        cfg(3'd3, 8'h03);
        pins = 6'b110001; tick(); pins = 6'h3F; tick();
        expect_req("R8 highest", 3'd1, 3'd5);
        ack();
        chk("R7 below mask", 32'(irq_req), 0);
        set_mask(3'd2);
        expect_req("R8 tie low index", 3'd2, 3'd3);
        ack();
        chk("R7 equal to mask", 32'(irq_req), 0);
        set_mask(3'd2);
        expect_req("R8 last pending", 3'd3, 3'd3);

        // R4: level source
        do_reset();
        cfg(3'd0, 8'h01);
        cfg(3'd2, 8'h02);
        pins[0] = 1'b0; tick();
        expect_req("R4 level", 3'd0, 3'd2);
        pins[0] = 1'b1; tick();
        chk("R4 withdrawn", 32'(irq_req), 0);
        pins[0] = 1'b0; tick();
        ack();
        chk("R4 ack id", 32'(ack_id), 0);
        chk("R4 mask", 32'(mask_level), 2);
        set_mask(3'd0);
        chk("R4 held after accept", 32'(irq_req), 0);
        pins[0] = 1'b1; tick(); pins[0] = 1'b0; tick();
        expect_req("R4 rearmed", 3'd0, 3'd2);
        cfg(3'd0, 8'h00);
        chk("R4 disabled", 32'(irq_req), 0);
        pins[0] = 1'b1;

        // R11: routing to the transfer engine
        do_reset();
        cfg(3'd0, 8'h04);
        cfg(3'd3, 8'h03);
        cfg(3'd4, 8'h04);
        pins[2] = 1'b0; tick();
        chk("R11 not presented", 32'(irq_req), 0);
        chk("R11 no pulse yet", 32'(xfer_start), 0);
        tick();
        chk("R11 pulse", 32'(xfer_start), 32'h04);
        chk("R11 mask kept", 32'(mask_level), 0);
        tick();
        chk("R11 one cycle", 32'(xfer_start), 0);
        pins[2] = 1'b1;
        cfg(3'd4, 8'h00);
        chk("R11 flag consumed", 32'(irq_req), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule